// File: doc/BRIEF.md
# Byte-Wide SPI Master with Collision and Mode-Fault Flags

This block moves one byte at a time between a processor and an SPI slave. The processor sees four byte-wide registers: control, status, data and one spare. Writing the data register while the block is idle, enabled and in master mode loads the byte into the shift register and starts a transfer. The block then toggles SCK at a rate set by a small divider and swaps the master's byte with the slave's byte over MOSI and MISO. When the transfer ends, the byte from the slave is copied into a read buffer. That buffer keeps its value while the next transfer runs.

There are two fault conditions. A write to the data register during a transfer is a write collision. The slave-select input going low while master mode is on is a mode fault. A mode fault drops the block out of master mode, releases the bus and abandons the current byte. Each flag clears through two steps: first a status read that returns the flag as set, then a particular register access. A data access clears the transfer-complete and collision flags. A control write clears the mode-fault flag. When the slave-select pin is set up as an output, the mode-fault check is switched off and the pin instead marks the transfer with an active-low select.

Top module: `spi_fault_top`

Register addresses (cpuAddr): 0 control, 1 status, 2 data, 3 reserved (reads 0).
Control byte: bit 7 interrupt enable, bit 6 block enable, bit 4 master, bit 3 slave-select pin is output, bits 2:0 divider value `d`.
Status byte: bit 7 transfer complete, bit 6 write collision, bit 4 mode fault, bit 0 busy. All other bits read 0.

## Requirements
- R1: A transfer shifts MSB first. SCK idles low, MISO is sampled on the rising SCK edge and MOSI changes on the falling edge. After eight SCK pulses the data register returns the slave's byte and the slave holds the master's byte.
- R2: Each SCK half-period lasts d+1 clock cycles, so successive rising SCK edges are 2*(d+1) cycles apart.
- R3: Reads of the data register return the last completed byte, including while a later transfer is in progress. SCK is low whenever no transfer is running.
- R4: A data write during a transfer sets status bit 6 and leaves the byte in flight, and the byte received, unchanged.
- R5: Status bit 6 clears only when a status read that returned it as 1 is followed by a read or write of the data register. A data access without that earlier status read leaves it set.
- R6: Status bit 7 sets when the eighth bit completes. It clears by the same status-read-then-data-access sequence as bit 6.
- R7: With enable and master set and the slave-select pin an input, a low level on ssIn sets status bit 4. It also clears control bit 4, stops the transfer, holds SCK low and drops the bus drive enable.
- R8: When control bit 3 is 1, a low ssIn never sets status bit 4. During a transfer ssOutN is low and ssOutEn is high.
- R9: Status bit 4 clears only when a status read that returned it as 1 is followed by a control write. A data access does not clear it.
- R10: irq equals control bit 7 AND (status bit 7 OR status bit 4).
- R11: After reset the control and status registers read 0, and SCK and irq are low.
- R12: A data write while the block is not in master mode loads the shifter but starts no transfer. Busy stays 0 and SCK stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Register access strobe, one cycle per access |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2 | Register select |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data, combinational from the selected register |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busOe | output | 1 | Drive enable for sck and mosi (master active) |
| ssIn | input | 1 | Slave-select input level, synchronized internally |
| ssOutN | output | 1 | Active-low select when the pin is an output |
| ssOutEn | output | 1 | Slave-select pin drive enable |

## Verification
The bench targets the two-step flag clearing. In one test a data access comes before any status read, and the check confirms the collision and complete flags stay set. A design that clears on the access alone would lose them there. A colliding write is placed in the middle of a byte, and the check confirms both the slave's received byte and the buffered byte are the originals. A design that let the write reach the shifter would corrupt both. The mode fault is raised in the middle of a transfer, and the check confirms the master bit is gone, SCK is parked low and a data read does not clear the flag. The same low select level is then applied with the pin set as an output, where a design that ignores the direction bit would raise a fault. SCK spacing is measured at two divider settings to catch an off-by-one in the divider.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam int REG_W  = 8;
  localparam int BAUD_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_RSVD = 2'd3
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/spi_fault_dp.sv
module spi_fault_dp #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  spi_fault_pkg::dpStrobe_t  strobe,
  input  logic                      busy,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      miso,
  output logic                      mosi,
  output logic [DATA_W-1:0]         rxData
);
  logic [DATA_W-1:0] shifter;
  logic              sampled;

  // data storage intentionally has no reset
  always_ff @(posedge clk) begin
    if (strobe.load)
      shifter <= wdata;
    else if (strobe.shift)
      shifter <= {shifter[DATA_W-2:0], sampled};
    if (strobe.sample)
      sampled <= miso;
    if (strobe.finish)
      rxData <= {shifter[DATA_W-2:0], sampled};
  end

  assign mosi = busy & shifter[DATA_W-1];
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cpuSel,
  input  logic                                cpuWr,
  input  logic [1:0]                          cpuAddr,
  input  logic [spi_fault_pkg::REG_W-1:0]     cpuWdata,
  input  logic                                ssIn,
  output spi_fault_pkg::dpStrobe_t            strobe,
  output logic                                busy,
  output logic                                sckOut,
  output logic                                busOe,
  output logic                                ssOutN,
  output logic                                ssOutEn,
  output logic                                irq,
  output logic                                doneFlag,
  output logic                                wcolFlag,
  output logic                                modfFlag,
  output logic [spi_fault_pkg::REG_W-1:0]     ctrlByte,
  output logic [spi_fault_pkg::REG_W-1:0]     statByte
);
  import spi_fault_pkg::*;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic               irqEn, spiEn, master, ssDir;
  logic [BAUD_W-1:0]  baud, divCnt;
  logic [CNT_W-1:0]   bitCnt;
  logic [SYNC_STAGES-1:0] ssSyncQ;
  logic               doneArm, wcolArm, modfArm;

  logic wrCtrl, rdStat, dataAcc, wrData;
  logic active, modfEvent, tick, lastBit;
  logic sampleS, shiftS, finishS, loadS, startS;
  logic doneClr, wcolClr, modfClr;

  // slave-select synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ssSyncQ <= '1;
    else       ssSyncQ <= {ssSyncQ[SYNC_STAGES-2:0], ssIn};
  end

  always_comb begin
    wrCtrl    = cpuSel & cpuWr & (cpuAddr == REG_CTRL);
    rdStat    = cpuSel & ~cpuWr & (cpuAddr == REG_STAT);
    dataAcc   = cpuSel & (cpuAddr == REG_DATA);
    wrData    = dataAcc & cpuWr;
    active    = spiEn & master;
    modfEvent = active & ~ssDir & ~ssSyncQ[SYNC_STAGES-1];
    tick      = (divCnt == '0);
    lastBit   = (bitCnt == LAST_BIT);
    sampleS   = busy & tick & ~sckOut & ~modfEvent;
    shiftS    = busy & tick & sckOut & ~modfEvent;
    finishS   = shiftS & lastBit;
    loadS     = wrData & ~busy;
    startS    = loadS & active & ~modfEvent;
    doneClr   = doneArm & dataAcc;
    wcolClr   = wcolArm & dataAcc;
    modfClr   = modfArm & wrCtrl;
    strobe    = '{load: loadS, sample: sampleS, shift: shiftS, finish: finishS};
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      spiEn  <= 1'b0;
      master <= 1'b0;
      ssDir  <= 1'b0;
      baud   <= '0;
    end else begin
      if (wrCtrl) begin
        irqEn  <= cpuWdata[7];
        spiEn  <= cpuWdata[6];
        master <= cpuWdata[4];
        ssDir  <= cpuWdata[3];
        baud   <= cpuWdata[BAUD_W-1:0];
      end
      if (modfEvent) master <= 1'b0;
    end
  end

  // bit timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sckOut <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (modfEvent) begin
      busy   <= 1'b0;
      sckOut <= 1'b0;
    end else if (startS) begin
      busy   <= 1'b1;
      sckOut <= 1'b0;
      divCnt <= baud;
      bitCnt <= '0;
    end else if (busy && tick) begin
      divCnt <= baud;
      sckOut <= ~sckOut;
      if (sckOut) begin
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) busy <= 1'b0;
      end
    end else if (busy) begin
      divCnt <= divCnt - 1'b1;
    end
  end

  // flags and their arming bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0; doneArm <= 1'b0;
      wcolFlag <= 1'b0; wcolArm <= 1'b0;
      modfFlag <= 1'b0; modfArm <= 1'b0;
    end else begin
      doneFlag <= finishS | (doneFlag & ~doneClr);
      if (doneClr || finishS)       doneArm <= 1'b0;
      else if (rdStat && doneFlag)  doneArm <= 1'b1;

      wcolFlag <= (wrData & busy) | (wcolFlag & ~wcolClr);
      if (wcolClr || (wrData && busy)) wcolArm <= 1'b0;
      else if (rdStat && wcolFlag)     wcolArm <= 1'b1;

      modfFlag <= modfEvent | (modfFlag & ~modfClr);
      if (modfClr || modfEvent)     modfArm <= 1'b0;
      else if (rdStat && modfFlag)  modfArm <= 1'b1;
    end
  end

  always_comb begin
    busOe    = spiEn & master;
    ssOutEn  = spiEn & ssDir;
    ssOutN   = ~(ssDir & busy);
    irq      = irqEn & (doneFlag | modfFlag);
    ctrlByte = {irqEn, spiEn, 1'b0, master, ssDir, baud};
    statByte = {doneFlag, wcolFlag, 1'b0, modfFlag, 3'b000, busy};
  end
endmodule

// File: rtl/spi_fault_top.sv
module spi_fault_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic [1:0] cpuAddr,
  input  logic [7:0] cpuWdata,
  output logic [7:0] cpuRdata,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       busOe,
  input  logic       ssIn,
  output logic       ssOutN,
  output logic       ssOutEn
);
  import spi_fault_pkg::*;
  localparam int DATA_W = REG_W;

  dpStrobe_t         strobe;
  logic              busy, doneFlag, wcolFlag, modfFlag;
  logic [REG_W-1:0]  ctrlByte, statByte;
  logic [DATA_W-1:0] rxData;

  spi_fault_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .ssIn(ssIn), .strobe(strobe), .busy(busy),
    .sckOut(sck), .busOe(busOe), .ssOutN(ssOutN), .ssOutEn(ssOutEn), .irq(irq),
    .doneFlag(doneFlag), .wcolFlag(wcolFlag), .modfFlag(modfFlag),
    .ctrlByte(ctrlByte), .statByte(statByte)
  );

  spi_fault_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .strobe(strobe), .busy(busy), .wdata(cpuWdata),
    .miso(miso), .mosi(mosi), .rxData(rxData)
  );

  always_comb begin
    case (cpuAddr)
      REG_CTRL: cpuRdata = ctrlByte;
      REG_STAT: cpuRdata = statByte;
      REG_DATA: cpuRdata = rxData;
      default:  cpuRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fault_checker.sv
module spi_fault_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sck,
  input logic       irq,
  input logic       busOe,
  input logic       cpuSel,
  input logic       cpuWr,
  input logic [1:0] cpuAddr,
  input logic       busy,
  input logic       doneFlag,
  input logic       wcolFlag,
  input logic       modfFlag
);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  assert_modf_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modfFlag) |-> (!busy && !busOe && !sck));

  assert_wcol_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wcolFlag) |-> $past(cpuSel && cpuAddr == 2'd2));

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(cpuSel && cpuAddr == 2'd2));

  assert_modf_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modfFlag) |-> $past(cpuSel && cpuWr && cpuAddr == 2'd0));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag || modfFlag));
endmodule

bind spi_fault_top spi_fault_checker i_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .irq(irq), .busOe(busOe),
  .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .busy(busy),
  .doneFlag(doneFlag), .wcolFlag(wcolFlag), .modfFlag(modfFlag)
);

// File: tb/test_spi_fault_top.sv
module test_spi_fault_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuSel = 1'b0, cpuWr = 1'b0;
  logic [1:0] cpuAddr = 2'd0;
  logic [7:0] cpuWdata = 8'd0;
  logic [7:0] cpuRdata;
  logic       irq, sck, mosi, miso, busOe, ssOutN, ssOutEn;
  logic       ssIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] slaveReg = 8'h00;
  logic       slaveIn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // simple slave: samples on rising SCK, shifts on falling SCK
  assign miso = slaveReg[7];
  always @(posedge sck) slaveIn = mosi;
  always @(negedge sck) slaveReg = {slaveReg[6:0], slaveIn};

  spi_fault_top i_spi_fault_top (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .busOe(busOe), .ssIn(ssIn), .ssOutN(ssOutN), .ssOutEn(ssOutEn)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = addr; cpuWdata = data;
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [1:0] addr, output logic [7:0] data);
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = 1'b0; cpuAddr = addr;
    #1 data = cpuRdata;
    @(negedge clk);
    cpuSel = 1'b0;
  endtask

  task automatic waitDone();
    logic [7:0] st;
    for (int i = 0; i < 200; i++) begin
      cpuRead(2'd1, st);
      if (st[7]) break;
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    cpuRead(2'd0, v); check("R11 ctrl", v, 8'h00);
    cpuRead(2'd1, v); check("R11 status", v, 8'h00);
    check("R11 sck", sck, 0);
    check("R11 irq", irq, 0);
  endtask

  task automatic testExchange();
    logic [7:0] v;
    cpuWrite(2'd0, 8'hD1);
    slaveReg = 8'h3C;
    cpuWrite(2'd2, 8'hA5);
    waitDone();
    check("R6 done irq", irq, 1);
    cpuRead(2'd2, v); check("R1 rx byte", v, 8'h3C);
    check("R1 slave byte", slaveReg, 8'hA5);
    cpuRead(2'd1, v); check("R6 done cleared", v, 8'h00);
    check("R10 irq low", irq, 0);
    // second byte: buffer holds old value mid-transfer
    slaveReg = 8'h81;
    cpuWrite(2'd2, 8'h42);
    repeat (5) @(negedge clk);
    cpuRead(2'd2, v); check("R3 buffered during transfer", v, 8'h3C);
    waitDone();
    cpuRead(2'd2, v); check("R1 second rx", v, 8'h81);
    check("R1 second slave", slaveReg, 8'h42);
    check("R3 sck idle", sck, 0);
  endtask

  task automatic testPeriod(input int d);
    logic [7:0] v;
    int t0, t1;
    cpuWrite(2'd0, 8'h50 | 8'(d));
    cpuWrite(2'd2, 8'h11);
    @(posedge sck); t0 = cyc;
    @(posedge sck); t1 = cyc;
    check("R2 sck period", t1 - t0, 2 * (d + 1));
    waitDone();
    cpuRead(2'd2, v);
  endtask

  task automatic testCollision();
    logic [7:0] v;
    cpuWrite(2'd0, 8'h51);
    slaveReg = 8'h3C;
    cpuWrite(2'd2, 8'hA5);
    repeat (4) @(negedge clk);
    cpuWrite(2'd2, 8'hFF);
    repeat (40) @(negedge clk);
    cpuRead(2'd2, v); check("R4 rx unchanged", v, 8'h3C);
    check("R4 slave got original", slaveReg, 8'hA5);
    cpuRead(2'd1, v); check("R5 data access alone keeps flags", v, 8'hC0);
    cpuRead(2'd2, v);
    cpuRead(2'd1, v); check("R5 flags cleared by sequence", v, 8'h00);
  endtask

  task automatic testModeFault();
    logic [7:0] v;
    cpuWrite(2'd0, 8'hD1);
    cpuWrite(2'd2, 8'h5A);
    repeat (6) @(negedge clk);
    ssIn = 1'b0;
    repeat (5) @(negedge clk);
    cpuRead(2'd1, v); check("R7 fault set, not busy", v, 8'h10);
    check("R7 sck low", sck, 0);
    check("R7 bus released", busOe, 0);
    check("R10 irq on fault", irq, 1);
    cpuRead(2'd0, v); check("R7 master cleared", v, 8'hC1);
    cpuRead(2'd2, v);
    cpuRead(2'd1, v); check("R9 data access keeps fault", v, 8'h10);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
    cpuWrite(2'd0, 8'h51);
    cpuRead(2'd1, v); check("R9 fault cleared by ctrl write", v, 8'h00);
  endtask

  task automatic testSsOutput();
    logic [7:0] v;
    cpuWrite(2'd0, 8'h59);
    ssIn = 1'b0;
    repeat (5) @(negedge clk);
    cpuRead(2'd1, v); check("R8 no fault with pin output", v, 8'h00);
    slaveReg = 8'h0F;
    cpuWrite(2'd2, 8'hF0);
    repeat (4) @(negedge clk);
    check("R8 select low", ssOutN, 0);
    check("R8 select driven", ssOutEn, 1);
    waitDone();
    cpuRead(2'd2, v); check("R8 transfer completes", v, 8'h0F);
    check("R8 select high after", ssOutN, 1);
    ssIn = 1'b1;
    cpuWrite(2'd0, 8'h51);
  endtask

  task automatic testNotMaster();
    logic [7:0] v;
    cpuWrite(2'd0, 8'h40);
    cpuWrite(2'd2, 8'h77);
    repeat (6) @(negedge clk);
    cpuRead(2'd1, v); check("R12 no transfer", v, 8'h00);
    check("R12 sck low", sck, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testExchange();
    testPeriod(0);
    testPeriod(3);
    testCollision();
    testModeFault();
    testSsOutput();
    testNotMaster();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule